// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-attached watchdog. Software programs a timeout limit and a control word, then starts counting. The control word picks one of three tick sources (system, real-time, external) and a prescale ratio that is a power of four. Each prescaled tick moves a 16-bit up-counter forward by one. When the counter reaches the limit, the block drives a one-cycle reset pulse to the rest of the chip. Software keeps the system alive by writing zero to the counter before that happens.

The three tick sources are single-cycle enable strobes in the `clk` domain. The bus is a simple word-indexed port. Writes complete in one cycle and have byte-lane strobes. Reads are combinational from the word index.

A four-state machine controls the sequence:

- OFF: counting is disabled.
- RUN: counting toward the limit.
- BITE: the one cycle in which the reset pulse is high.
- SPENT: expired and holding.

The transitions are:

- arm (OFF→RUN) happens when the enable bit is set.
- expire (RUN→BITE) happens when the count equals the limit.
- settle (BITE→SPENT) happens on the following cycle.
- kick (RUN, BITE or SPENT→RUN) happens on any write to the counter register.
- halt (RUN, BITE or SPENT→OFF) happens when the enable bit is cleared. halt takes priority over kick.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, all four registers read back 0 and `wdt_rst_o` is low.
- R2: The word index selects the register: 0 is the limit, 1 is the enable bit (bit 0), 2 is the live counter, and 3 is control. In control, bits [2:0] are the source select and bits [5:3] are the divide code. Bits that are not implemented read as 0.
- R3: A write updates only the byte lanes whose `bus_strb` bit is set. Lane 0 is bits [7:0] and lane 1 is bits [15:8].
- R4: While enabled, the counter advances by exactly one per prescaled tick. While disabled, it holds its value.
- R5: The source-select bits choose the tick source: bit 0 selects the system tick, bit 1 the real-time tick and bit 2 the external tick. When several bits are set, the lowest-numbered one wins. When none is set, the counter never advances. Ticks from sources that are not selected are ignored.
- R6: Divide code n (0 to 5) gives one count per 4^n selected ticks. Codes 6 and 7 behave like code 5, which is /1024.
- R7: The prescaler restarts from zero whenever counting is disabled or the control register is written.
- R8: The counter reaches the limit at some clock edge. In the cycle after that edge, `wdt_rst_o` is high for exactly one cycle. The counter then holds, and no further pulse follows.
- R9: A counter write loads the written value and re-arms the timer. Writing 0 is the kick. After expiry, a kick allows a new pulse.
- R10: Clearing the enable bit stops counting. No reset pulse occurs while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_strb | input | 2 | Byte-lane write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick_sys | input | 1 | System tick enable |
| tick_rtc | input | 1 | Real-time tick enable |
| tick_ext | input | 1 | External tick enable |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Register writes take effect at the clock edge that ends the write cycle. A read later in the same cycle therefore shows the new value. A selected tick that completes a prescale period increments the counter at the edge that closes its cycle. The reset pulse appears one edge after the counter reaches the limit and lasts one cycle. The bench drives every stimulus at a falling edge, holds it across exactly one rising edge, and reads results at the next falling edge. For the pulse, it samples at the falling edges just after the reach edge, after the fire edge and after the edge that follows, and it also keeps a running count of pulse cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_BITE  = 2'd2,
        ST_SPENT = 2'd3
    } wdt_state_t;

    typedef struct packed {
        logic [2:0] div;
        logic [2:0] src;
    } wdt_ctl_t;

    localparam logic [1:0] IDX_LIMIT = 2'd0;
    localparam logic [1:0] IDX_EN    = 2'd1;
    localparam logic [1:0] IDX_COUNT = 2'd2;
    localparam logic [1:0] IDX_CTL   = 2'd3;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LANES = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [LANES-1:0] bus_strb,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] limit_q,
    output logic             en_q,
    output wdt_ctl_t         ctl_q,
    output logic             ctl_wr,
    output logic             cnt_wr,
    output logic [CNT_W-1:0] cnt_wval
);
    logic [CNT_W-1:0] limit_merged;
    logic [CNT_W-1:0] cnt_merged;
    logic             lim_wr;
    logic             en_wr;

    // Per-lane merge of write data over current register contents
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign limit_merged[g*8 +: 8] = bus_strb[g] ? bus_wdata[g*8 +: 8] : limit_q[g*8 +: 8];
        assign cnt_merged[g*8 +: 8]   = bus_strb[g] ? bus_wdata[g*8 +: 8] : cnt_i[g*8 +: 8];
    end

    assign lim_wr   = bus_we && (bus_addr == IDX_LIMIT) && (|bus_strb);
    assign en_wr    = bus_we && (bus_addr == IDX_EN) && bus_strb[0];
    assign ctl_wr   = bus_we && (bus_addr == IDX_CTL) && bus_strb[0];
    assign cnt_wr   = bus_we && (bus_addr == IDX_COUNT) && (|bus_strb);
    assign cnt_wval = cnt_merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
            en_q    <= 1'b0;
            ctl_q   <= '0;
        end else begin
            if (lim_wr) limit_q <= limit_merged;
            if (en_wr)  en_q    <= bus_wdata[0];
            if (ctl_wr) ctl_q   <= bus_wdata[5:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            IDX_LIMIT: bus_rdata = limit_q;
            IDX_EN:    bus_rdata[0] = en_q;
            IDX_COUNT: bus_rdata = cnt_i;
            IDX_CTL:   bus_rdata[5:0] = ctl_q;
        endcase
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int MAX_CODE = 5,
    localparam int PRE_W = 2 * MAX_CODE
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  wdt_ctl_t ctl,
    input  logic     tick_sys,
    input  logic     tick_rtc,
    input  logic     tick_ext,
    output logic     pre_tick
);
    logic             sel_tick;
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] limit;
    logic [2:0]       eff_code;

    // Lowest-numbered selected source wins
    always_comb begin
        if (ctl.src[0])      sel_tick = tick_sys;
        else if (ctl.src[1]) sel_tick = tick_rtc;
        else if (ctl.src[2]) sel_tick = tick_ext;
        else                 sel_tick = 1'b0;
    end

    assign eff_code = (int'(ctl.div) > MAX_CODE) ? 3'(MAX_CODE) : ctl.div;
    assign limit    = PRE_W'((PRE_W+1)'(1) << (2 * eff_code)) - PRE_W'(1);
    assign pre_tick = sel_tick && (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt <= '0;
        else if (clr)      pcnt <= '0;
        else if (sel_tick) pcnt <= pre_tick ? '0 : pcnt + PRE_W'(1);
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pre_tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wdt_rst_o
);
    wdt_state_t state_q, state_d;
    logic       at_limit;
    logic       may_count;

    assign at_limit  = (cnt_q == limit);
    assign may_count = en && ((state_q == ST_OFF) || (state_q == ST_RUN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en) state_d = ST_RUN;
            ST_RUN: begin
                if (!en)          state_d = ST_OFF;
                else if (cnt_wr)  state_d = ST_RUN;
                else if (at_limit) state_d = ST_BITE;
            end
            ST_BITE: begin
                if (!en)         state_d = ST_OFF;
                else if (cnt_wr) state_d = ST_RUN;
                else             state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (!en)         state_d = ST_OFF;
                else if (cnt_wr) state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= cnt_wval;
        else if (may_count && pre_tick && !at_limit)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        wdt_rst_o = (state_q == ST_BITE);
    end
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_CODE = 5,
    localparam int LANES   = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [LANES-1:0] bus_strb,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             tick_sys,
    input  logic             tick_rtc,
    input  logic             tick_ext,
    output logic             wdt_rst_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_wval;
    logic             en_q;
    logic             ctl_wr;
    logic             cnt_wr;
    logic             pre_tick;
    wdt_ctl_t         ctl_q;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_strb  (bus_strb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_i     (cnt_q),
        .limit_q   (limit_q),
        .en_q      (en_q),
        .ctl_q     (ctl_q),
        .ctl_wr    (ctl_wr),
        .cnt_wr    (cnt_wr),
        .cnt_wval  (cnt_wval)
    );

    wdt_prescaler #(.MAX_CODE(MAX_CODE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en_q || ctl_wr),
        .ctl      (ctl_q),
        .tick_sys (tick_sys),
        .tick_rtc (tick_rtc),
        .tick_ext (tick_ext),
        .pre_tick (pre_tick)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .pre_tick  (pre_tick),
        .limit     (limit_q),
        .cnt_wr    (cnt_wr),
        .cnt_wval  (cnt_wval),
        .cnt_q     (cnt_q),
        .wdt_rst_o (wdt_rst_o)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_o,
    input logic             en_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] limit_q,
    input logic             cnt_wr,
    input logic [2:0]       src_sel,
    input logic             pre_tick
);
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);

    p_fire_after_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(cnt_q == limit_q));

    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q)) |-> !rst_o);

    p_no_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'b000) |-> !pre_tick);
endmodule

bind wdt_prescaled wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_o    (wdt_rst_o),
    .en_q     (en_q),
    .cnt_q    (cnt_q),
    .limit_q  (limit_q),
    .cnt_wr   (cnt_wr),
    .src_sel  (ctl_q.src),
    .pre_tick (pre_tick)
);

// File: tb/tb_wdt_prescaled.sv
`timescale 1ns/1ps
module tb_wdt_prescaled;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_strb = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_sys = 1'b0, tick_rtc = 1'b0, tick_ext = 1'b0;
    logic        wdt_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    wdt_prescaled dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_sys(tick_sys), .tick_rtc(tick_rtc), .tick_ext(tick_ext),
        .wdt_rst_o(wdt_rst_o)
    );

    always @(posedge clk) if (rst_n && wdt_rst_o) pulses++;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] s = 2'b11);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_strb = s; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_strb = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // which: 0 system, 1 real-time, 2 external
    task automatic ticks(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_sys = (which == 0); tick_rtc = (which == 1); tick_ext = (which == 2);
            @(negedge clk);
            tick_sys = 1'b0; tick_rtc = 1'b0; tick_ext = 1'b0;
        end
    endtask

    task automatic setup(input logic [5:0] ctl, input logic [15:0] lim);
        wr(2'd1, 16'h0000);
        wr(2'd3, {10'd0, ctl});
        wr(2'd0, lim);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0001);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset readback", v, 16'h0000);
        end
        chk("R1 reset output low", {15'd0, wdt_rst_o}, 16'h0000);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(2'd0, 16'h1234);         rd(2'd0, v); chk("R2 limit readback", v, 16'h1234);
        wr(2'd3, 16'hFFC0);         rd(2'd3, v); chk("R2 control unused bits zero", v, 16'h0000);
        wr(2'd3, 16'hFFFF);         rd(2'd3, v); chk("R2 control readback", v, 16'h003F);
        wr(2'd1, 16'hFFFE);         rd(2'd1, v); chk("R2 enable bit zero", v, 16'h0000);
        wr(2'd0, 16'h00AB, 2'b01);  rd(2'd0, v); chk("R3 low lane only", v, 16'h12AB);
        wr(2'd0, 16'hCD00, 2'b10);  rd(2'd0, v); chk("R3 high lane only", v, 16'hCDAB);
        wr(2'd0, 16'h5555, 2'b00);  rd(2'd0, v); chk("R3 no lanes", v, 16'hCDAB);
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_count;
        logic [15:0] v;
        setup(6'h01, 16'hFFFF);
        ticks(0, 5);  rd(2'd2, v); chk("R4 counts system ticks", v, 16'd5);
        ticks(1, 4);  rd(2'd2, v); chk("R5 unselected rtc ignored", v, 16'd5);
        ticks(2, 4);  rd(2'd2, v); chk("R5 unselected ext ignored", v, 16'd5);
        wr(2'd1, 16'h0000);
        ticks(0, 3);  rd(2'd2, v); chk("R4 holds while disabled", v, 16'd5);
    endtask

    task automatic t_source;
        logic [15:0] v;
        setup(6'h06, 16'hFFFF);
        ticks(1, 3);  rd(2'd2, v); chk("R5 rtc wins over ext", v, 16'd3);
        ticks(2, 3);  rd(2'd2, v); chk("R5 ext loses to rtc", v, 16'd3);
        wr(2'd3, 16'h0004);
        ticks(2, 2);  rd(2'd2, v); chk("R5 ext alone selected", v, 16'd5);
        wr(2'd3, 16'h0000);
        ticks(0, 2); ticks(1, 2); ticks(2, 2);
        rd(2'd2, v); chk("R5 no source never advances", v, 16'd5);
    endtask

    task automatic t_divide;
        logic [15:0] v;
        setup(6'h09, 16'hFFFF);
        ticks(0, 7);  rd(2'd2, v); chk("R6 /4 after 7 ticks", v, 16'd1);
        ticks(0, 1);  rd(2'd2, v); chk("R6 /4 after 8 ticks", v, 16'd2);
        setup(6'h21, 16'hFFFF);
        ticks(0, 255); rd(2'd2, v); chk("R6 /256 after 255", v, 16'd0);
        ticks(0, 1);   rd(2'd2, v); chk("R6 /256 after 256", v, 16'd1);
        setup(6'h39, 16'hFFFF);
        ticks(0, 1023); rd(2'd2, v); chk("R6 code 7 after 1023", v, 16'd0);
        ticks(0, 1);    rd(2'd2, v); chk("R6 code 7 acts as /1024", v, 16'd1);
    endtask

    task automatic t_preclear;
        logic [15:0] v;
        setup(6'h09, 16'hFFFF);
        ticks(0, 3);
        wr(2'd1, 16'h0000); wr(2'd1, 16'h0001);
        ticks(0, 3);  rd(2'd2, v); chk("R7 disable restarts prescaler", v, 16'd0);
        ticks(0, 1);  rd(2'd2, v); chk("R7 full period after enable", v, 16'd1);
        ticks(0, 3);
        wr(2'd3, 16'h0009);
        ticks(0, 3);  rd(2'd2, v); chk("R7 control write restarts prescaler", v, 16'd1);
        ticks(0, 1);  rd(2'd2, v); chk("R7 full period after control write", v, 16'd2);
    endtask

    task automatic t_expire;
        logic [15:0] v;
        setup(6'h01, 16'd3);
        pulses = 0;
        ticks(0, 2);
        @(negedge clk); tick_sys = 1'b1;
        @(negedge clk); tick_sys = 1'b0;
        chk("R8 low on reach edge", {15'd0, wdt_rst_o}, 16'd0);
        @(negedge clk);
        chk("R8 high one edge later", {15'd0, wdt_rst_o}, 16'd1);
        @(negedge clk);
        chk("R8 low after one cycle", {15'd0, wdt_rst_o}, 16'd0);
        ticks(0, 4);
        rd(2'd2, v); chk("R8 counter holds at limit", v, 16'd3);
        chk("R8 single pulse", 16'(pulses), 16'd1);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); chk("R9 kick clears counter", v, 16'd0);
        ticks(0, 3); repeat (3) @(negedge clk);
        chk("R9 rearmed pulse after kick", 16'(pulses), 16'd2);
        wr(2'd2, 16'h0002);
        rd(2'd2, v); chk("R9 counter load value", v, 16'd2);
        ticks(0, 1); repeat (3) @(negedge clk);
        chk("R9 pulse after loaded count", 16'(pulses), 16'd3);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        setup(6'h01, 16'd2);
        pulses = 0;
        ticks(0, 1);
        wr(2'd1, 16'h0000);
        ticks(0, 5); repeat (3) @(negedge clk);
        rd(2'd2, v); chk("R10 stopped count", v, 16'd1);
        chk("R10 no pulse while disabled", 16'(pulses), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_source();
        t_divide();
        t_preclear();
        t_expire();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule